// File: doc/BRIEF.md
# SMBus Bus State Monitor

This block watches the two lines of a two-wire SMBus (clock and data, both already synchronised to the system clock) and keeps track of whether a transfer is in progress. A START condition marks the bus as busy. The busy flag drops again on a STOP condition, or when both lines have stayed high for longer than a fixed number of bit-rate periods (the free timeout). The bit-rate period comes from one of four timer overflow pulses, chosen by a 2-bit field in a control byte.

The block also runs the clock-low watchdog for an external timer. It holds the timer in reload while the clock line is high and lets it count while the line is low. In split mode only the timer's high byte is held. It gates the slave and master event interrupts and passes the extended setup/hold option through to the data-path timing logic. It does not shift data, generate the clock waveform, match addresses, or contain the timer itself.

Top module: `smb_bus_monitor`

## Requirements
- R1: After synchronous reset every control bit is 0, busy is 0, and the timer-reload, count-enable, interrupt and extended-hold outputs are all 0.
- R2: While the enable bit is 0, line activity is ignored. Busy is forced to 0 one cycle after enable is seen low, the free-timeout count is cleared, and the reload, count-enable and interrupt outputs stay 0.
- R3: While enabled, a START (data sampled high then low while the clock is high on both samples) sets busy on the following cycle.
- R4: While enabled, a STOP (data sampled low then high while the clock is high on both samples) clears busy on the following cycle.
- R5: With the free-timeout bit set, busy clears on the 11th selected overflow pulse counted while both lines are high. Ten pulses leave it set. Any cycle with either line low restarts the count from zero.
- R6: Clock-source select value 00 picks overflow input bit 0 (timer 0), 01 picks bit 1 (timer 1), 10 picks bit 2 (timer 2 high byte) and 11 picks bit 3 (timer 2 low byte). Pulses on the unselected inputs are not counted.
- R7: With enable and the SCL-timeout bit set, both reload outputs are high while the clock line is high, and count-enable is high while the line is low. With the SCL-timeout bit clear, all three outputs are low.
- R8: When the split input is high, the low-byte reload stays low while the high-byte reload follows R7.
- R9: When the slave-inhibit bit is set, the slave interrupt output is held low, while the master interrupt output still follows the master event input (when enabled).
- R10: The extended setup/hold bit appears unchanged on its own output.
- R11: Control byte layout: bit 7 enable, bit 6 slave inhibit, bit 5 extended setup/hold, bit 4 SCL-timeout enable, bit 3 free-timeout enable, bit 2 reserved (stored as 0), bits 1:0 clock-source select. The byte is written on a cycle with the write strobe high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control byte write strobe |
| cfg_wdata | input | 8 | Control byte value (layout in R11) |
| scl_in | input | 1 | Synchronised clock line level |
| sda_in | input | 1 | Synchronised data line level |
| ovf_src | input | 4 | Overflow pulses, index equals the select code |
| split_mode | input | 1 | External timer runs as two bytes |
| slv_event | input | 1 | Slave event from the transfer logic |
| mst_event | input | 1 | Master event from the transfer logic |
| busy | output | 1 | Transfer in progress |
| tmr_reload_hi | output | 1 | Hold timer high byte in reload |
| tmr_reload_lo | output | 1 | Hold timer low byte in reload |
| tmr_count_en | output | 1 | Let the timer count |
| slv_irq | output | 1 | Gated slave interrupt |
| mst_irq | output | 1 | Gated master interrupt |
| ext_hold | output | 1 | Extended setup/hold option |

## Verification
The hardest state to reach is a busy bus with both lines high and no STOP, because raising data while the clock is high ends the transfer. The stimulus issues a START, drops the clock, raises the data line, and only then raises the clock, which gives an idle-looking bus that is still busy. On that bus the stimulus breaks the count with a one-cycle clock-low pulse, sends exactly ten selected ticks and a tick on an unselected source, and then sends the eleventh tick that frees the bus.

// File: rtl/smb_mon_pkg.sv
package smb_mon_pkg;

    localparam int unsigned CFG_W = 8;
    localparam int unsigned N_SRC = 4;

    typedef enum logic [1:0] {
        SRC_T0  = 2'b00,
        SRC_T1  = 2'b01,
        SRC_T2H = 2'b10,
        SRC_T2L = 2'b11
    } clk_src_e;

    typedef struct packed {
        logic     enable;
        logic     inhibit;
        logic     ext_hold;
        logic     scl_to_en;
        logic     free_to_en;
        logic     rsvd;
        clk_src_e src;
    } cfg_t;

    function automatic logic is_start(input logic scl_now, input logic scl_prev,
                                      input logic sda_now, input logic sda_prev);
        return scl_now & scl_prev & sda_prev & ~sda_now;
    endfunction

    function automatic logic is_stop(input logic scl_now, input logic scl_prev,
                                     input logic sda_now, input logic sda_prev);
        return scl_now & scl_prev & ~sda_prev & sda_now;
    endfunction

endpackage

// File: rtl/smb_cfg_reg.sv
module smb_cfg_reg
    import smb_mon_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output cfg_t             cfg_q
);
    cfg_t next_cfg;

    always_comb begin
        next_cfg      = cfg_t'(wdata);
        next_cfg.rsvd = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (we) begin
            cfg_q <= next_cfg;
        end
    end
endmodule

// File: rtl/smb_line_watch.sv
module smb_line_watch
    import smb_mon_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic scl,
    input  logic sda,
    output logic start_evt,
    output logic stop_evt,
    output logic lines_high
);
    logic scl_prev;
    logic sda_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_prev <= scl;
            sda_prev <= sda;
        end
    end

    assign start_evt  = en & is_start(scl, scl_prev, sda, sda_prev);
    assign stop_evt   = en & is_stop(scl, scl_prev, sda, sda_prev);
    assign lines_high = scl & sda;
endmodule

// File: rtl/smb_free_timer.sv
module smb_free_timer
    import smb_mon_pkg::*;
#(
    parameter int unsigned FREE_LIMIT = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  clk_src_e         src,
    input  logic [N_SRC-1:0] ovf,
    input  logic             lines_high,
    output logic             free_evt,
    output logic [$clog2(FREE_LIMIT+2)-1:0] cnt
);
    localparam int unsigned CW = $clog2(FREE_LIMIT + 2);
    localparam logic [CW-1:0] CNT_TOP = CW'(FREE_LIMIT + 1);

    logic [N_SRC-1:0] picked;
    logic             tick;

    for (genvar i = 0; i < N_SRC; i++) begin : g_pick
        assign picked[i] = ovf[i] & (src == clk_src_e'(i));
    end

    assign tick     = |picked;
    assign free_evt = run & lines_high & tick & (cnt == CNT_TOP - 1'b1);

    always_ff @(posedge clk) begin
        if (rst || !run || !lines_high) begin
            cnt <= '0;
        end else if (tick && cnt != CNT_TOP) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/smb_bus_monitor.sv
module smb_bus_monitor
    import smb_mon_pkg::*;
#(
    parameter int unsigned FREE_LIMIT = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             scl_in,
    input  logic             sda_in,
    input  logic [N_SRC-1:0] ovf_src,
    input  logic             split_mode,
    input  logic             slv_event,
    input  logic             mst_event,
    output logic             busy,
    output logic             tmr_reload_hi,
    output logic             tmr_reload_lo,
    output logic             tmr_count_en,
    output logic             slv_irq,
    output logic             mst_irq,
    output logic             ext_hold
);
    localparam int unsigned CW = $clog2(FREE_LIMIT + 2);

    cfg_t          cfg_q;
    logic          start_evt;
    logic          stop_evt;
    logic          lines_high;
    logic          free_evt;
    logic [CW-1:0] free_cnt;
    logic          watch_on;

    smb_cfg_reg u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .cfg_q (cfg_q)
    );

    smb_line_watch u_watch (
        .clk        (clk),
        .rst        (rst),
        .en         (cfg_q.enable),
        .scl        (scl_in),
        .sda        (sda_in),
        .start_evt  (start_evt),
        .stop_evt   (stop_evt),
        .lines_high (lines_high)
    );

    smb_free_timer #(.FREE_LIMIT(FREE_LIMIT)) u_free (
        .clk        (clk),
        .rst        (rst),
        .run        (cfg_q.enable & cfg_q.free_to_en),
        .src        (cfg_q.src),
        .ovf        (ovf_src),
        .lines_high (lines_high),
        .free_evt   (free_evt),
        .cnt        (free_cnt)
    );

    always_ff @(posedge clk) begin
        if (rst || !cfg_q.enable) begin
            busy <= 1'b0;
        end else if (start_evt) begin
            busy <= 1'b1;
        end else if (stop_evt || free_evt) begin
            busy <= 1'b0;
        end
    end

    assign watch_on      = cfg_q.enable & cfg_q.scl_to_en;
    assign tmr_reload_hi = watch_on & scl_in;
    assign tmr_reload_lo = watch_on & scl_in & ~split_mode;
    assign tmr_count_en  = watch_on & ~scl_in;
    assign slv_irq       = cfg_q.enable & ~cfg_q.inhibit & slv_event;
    assign mst_irq       = cfg_q.enable & mst_event;
    assign ext_hold      = cfg_q.ext_hold;
endmodule

// File: rtl/smb_mon_checker.sv
module smb_mon_checker #(
    parameter int unsigned FREE_LIMIT = 10
) (
    input logic                            clk,
    input logic                            rst,
    input logic                            en,
    input logic                            inh,
    input logic                            split,
    input logic                            start_evt,
    input logic                            stop_evt,
    input logic                            busy,
    input logic                            reload_hi,
    input logic                            reload_lo,
    input logic                            count_en,
    input logic                            slv_irq,
    input logic [$clog2(FREE_LIMIT+2)-1:0] free_cnt
);
    AST_DIS_CLEARS_BUSY: assert property (@(posedge clk) disable iff (rst) !en |=> !busy); // R2
    AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (rst) start_evt |=> busy); // R3
    AST_BUSY_RISE_CAUSE: assert property (@(posedge clk) disable iff (rst) $rose(busy) |-> $past(start_evt)); // R3
    AST_STOP_CLEARS_BUSY: assert property (@(posedge clk) disable iff (rst) (stop_evt && en) |=> !busy); // R4
    AST_FREE_CNT_BOUND: assert property (@(posedge clk) disable iff (rst) free_cnt <= ($clog2(FREE_LIMIT+2))'(FREE_LIMIT + 1)); // R5
    AST_RELOAD_COUNT_EXCL: assert property (@(posedge clk) disable iff (rst) !(count_en && reload_hi)); // R7
    AST_SPLIT_LOW_HELD: assert property (@(posedge clk) disable iff (rst) split |-> !reload_lo); // R8
    AST_INHIBIT_SLAVE: assert property (@(posedge clk) disable iff (rst) inh |-> !slv_irq); // R9
endmodule

bind smb_bus_monitor smb_mon_checker #(.FREE_LIMIT(FREE_LIMIT)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .en        (cfg_q.enable),
    .inh       (cfg_q.inhibit),
    .split     (split_mode),
    .start_evt (start_evt),
    .stop_evt  (stop_evt),
    .busy      (busy),
    .reload_hi (tmr_reload_hi),
    .reload_lo (tmr_reload_lo),
    .count_en  (tmr_count_en),
    .slv_irq   (slv_irq),
    .free_cnt  (free_cnt)
);

// File: tb/test_smb_bus_monitor.sv
module test_smb_bus_monitor;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic       scl_in = 1'b1;
    logic       sda_in = 1'b1;
    logic [3:0] ovf_src = '0;
    logic       split_mode = 1'b0;
    logic       slv_event = 1'b0;
    logic       mst_event = 1'b0;
    logic       busy, tmr_reload_hi, tmr_reload_lo, tmr_count_en, slv_irq, mst_irq, ext_hold;

    int n_vec = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    smb_bus_monitor i_smb_bus_monitor (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .scl_in(scl_in), .sda_in(sda_in), .ovf_src(ovf_src),
        .split_mode(split_mode), .slv_event(slv_event), .mst_event(mst_event),
        .busy(busy), .tmr_reload_hi(tmr_reload_hi), .tmr_reload_lo(tmr_reload_lo),
        .tmr_count_en(tmr_count_en), .slv_irq(slv_irq), .mst_irq(mst_irq),
        .ext_hold(ext_hold)
    );

    // {cfg[7:0], scl, split, slv, mst, exp reload_hi, reload_lo, count_en, slv_irq, mst_irq}
    localparam int NV = 8;
    localparam logic [16:0] VEC [NV] = '{
        {8'h00, 4'b1011, 5'b00000},  // R2 disabled
        {8'h90, 4'b1011, 5'b11011},  // R7 scl high reload
        {8'h90, 4'b1100, 5'b10000},  // R8 split
        {8'h90, 4'b0010, 5'b00110},  // R7 scl low count
        {8'hD0, 4'b0011, 5'b00101},  // R9 inhibit
        {8'hC0, 4'b1011, 5'b00001},  // R9 inhibit, R7 off
        {8'h80, 4'b0010, 5'b00010},  // R7 off
        {8'h10, 4'b0000, 5'b00000}   // R2 disabled
    };

    task automatic step();
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [7:0] b);
        cfg_we = 1'b1;
        cfg_wdata = b;
        step();
        cfg_we = 1'b0;
    endtask

    task automatic do_start();
        scl_in = 1'b1; sda_in = 1'b1; step();
        sda_in = 1'b0; step();
    endtask

    task automatic do_stop();
        scl_in = 1'b1; sda_in = 1'b0; step();
        sda_in = 1'b1; step();
    endtask

    task automatic busy_idle_lines();
        do_start();
        scl_in = 1'b0; step();
        sda_in = 1'b1; step();
        scl_in = 1'b1; step();
    endtask

    task automatic tick(input int idx);
        ovf_src[idx] = 1'b1; step();
        ovf_src = '0; step();
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        n_vec++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        step(); step();
        rst = 1'b0;
        step();
        #1;
        // R1 reset state
        check("R1", {1'b0, busy, tmr_reload_hi, tmr_reload_lo, tmr_count_en, slv_irq, mst_irq, ext_hold}, 8'h00);

        for (int i = 0; i < NV; i++) begin
            write_cfg(VEC[i][16:9]);
            scl_in = VEC[i][8]; split_mode = VEC[i][7];
            slv_event = VEC[i][6]; mst_event = VEC[i][5];
            #1;
            check("R7/R8/R9/R2 vector",
                  {3'b0, tmr_reload_hi, tmr_reload_lo, tmr_count_en, slv_irq, mst_irq},
                  {3'b0, VEC[i][4:0]});
            step();
        end
        scl_in = 1'b1; sda_in = 1'b1; split_mode = 0; slv_event = 0; mst_event = 0;

        // R10, R11 extended hold bit 5
        write_cfg(8'h20); #1;
        check("R10", {7'b0, ext_hold}, 8'h01);
        write_cfg(8'h00); #1;
        check("R10", {7'b0, ext_hold}, 8'h00);

        // R2 start ignored while disabled
        do_start(); #1;
        check("R2", {7'b0, busy}, 8'h00);
        scl_in = 1'b0; step(); sda_in = 1'b1; step(); scl_in = 1'b1; step();

        // R3 start sets busy, R4 stop clears
        write_cfg(8'h80);
        do_start(); #1;
        check("R3", {7'b0, busy}, 8'h01);
        do_stop(); #1;
        check("R4", {7'b0, busy}, 8'h00);

        // R2 disable clears busy
        do_start(); #1;
        check("R3", {7'b0, busy}, 8'h01);
        write_cfg(8'h00);
        step(); #1;
        check("R2", {7'b0, busy}, 8'h00);

        // R5 / R6 free timeout, source 00 (timer 0)
        write_cfg(8'h88);
        busy_idle_lines();
        for (int k = 0; k < 6; k++) tick(0);
        scl_in = 1'b0; step(); scl_in = 1'b1; step();
        for (int k = 0; k < 10; k++) tick(0);
        #1;
        check("R5 ten ticks", {7'b0, busy}, 8'h01);
        tick(1); tick(2); tick(3); #1;
        check("R6 unselected", {7'b0, busy}, 8'h01);
        tick(0); #1;
        check("R5 eleventh tick", {7'b0, busy}, 8'h00);

        // R6 source 10 picks timer 2 high byte (bit 2)
        write_cfg(8'h8A);
        busy_idle_lines();
        for (int k = 0; k < 11; k++) tick(3);
        #1;
        check("R6 sel10 ignores bit3", {7'b0, busy}, 8'h01);
        for (int k = 0; k < 11; k++) tick(2);
        #1;
        check("R6 sel10 bit2", {7'b0, busy}, 8'h00);

        // R5 free timeout off: no clear
        write_cfg(8'h80);
        busy_idle_lines();
        for (int k = 0; k < 12; k++) tick(0);
        #1;
        check("R5 disabled timeout", {7'b0, busy}, 8'h01);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule